// File: doc/BRIEF.md
# Buffered 16-bit Timer/Counter

This is a 16-bit up-counter that sits on a byte-wide peripheral register bus. It counts one of two sources. The first is a one-cycle tick pulse at the internal instruction rate. The second is an external clock pin. The external pin goes through a two-flop synchronizer, which software can bypass, and then through a rising-edge detector. The detector is only armed after it has seen a falling edge while external counting is active.

Either source then feeds a prescaler that divides by 1, 2, 4 or 8. Software can read and write the count one byte at a time. A buffered mode keeps a pair of byte accesses coherent, so both bytes refer to the same instant of the count.

When the count wraps from all ones to zero, the block sets a sticky interrupt flag. A special-event trigger input forces the count to zero. Two control bits select whether this timer or a sibling timer drives each of two capture/compare units.

Top module: `tmr16_buffered`

## Requirements
- R1: After reset the control register, the count, the buffered high byte and the interrupt flag are all 0, and both unit-select outputs are 0.
- R2: Address 0 is the control register. All 8 bits are read/write. Bit 7 is wide (buffered) mode, bit 6 is the upper route bit, bits 5:4 are the divide select, bit 3 is the lower route bit, bit 2 bypasses the synchronizer, bit 1 selects the external source, and bit 0 is run.
- R3: With run=1 and the external source off, every cycle in which tick_in is high produces one prescaler event, and ext_clk has no effect on the count.
- R4: The divide select 00/01/10/11 makes the count advance once per 1/2/4/8 source events.
- R5: With run=1 and the external source on, the count advances on ext_clk rising edges. A rising edge counts only after a falling edge has been seen since external counting last became active. tick_in is ignored in this mode.
- R6: With the external source on and the prescaler at divide by 1, an ext_clk rise that is stable before a clock edge appears on count_out after the third rising clock edge when synchronized (bit 2 = 0), and after the first rising clock edge when bypassed (bit 2 = 1).
- R7: With run=0 the count holds its value whatever the sources do.
- R8: In byte mode (bit 7 = 0), address 1 reads and writes the low count byte and address 2 the high count byte. Each access acts on its own byte at once.
- R9: In wide mode, a read of address 1 copies the live high byte into a buffer at the end of that read. Reads of address 2 return that buffer.
- R10: In wide mode, a write to address 2 loads only the buffer and leaves the count unchanged. A following write to address 1 loads the count with {buffer, written byte} in one step.
- R11: A wrap of the count from 0xFFFF to 0x0000 sets irq_flag. The flag is read as bit 0 of address 3. It stays set until a bus write of 0x00 to address 3, and a nonzero write leaves it set.
- R12: A cycle with evt_clear high sets the count to 0 at the next edge, unless a count write happens in that same cycle. It also clears the prescaler.
- R13: unit1_self equals control bit 6, and unit2_self equals bit 6 OR bit 3. A value of 1 means this timer drives that unit, and 0 means the sibling timer does.
- R14: Any write to address 1 or 2 that changes the count clears the prescaler's partial progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| tick_in | input | 1 | Internal instruction-rate tick pulse |
| ext_clk | input | 1 | External clock pin |
| evt_clear | input | 1 | Special-event trigger, clears the count |
| count_out | output | 16 | Live count value |
| irq_flag | output | 1 | Sticky overflow flag |
| unit1_self | output | 1 | Capture/compare unit 1 uses this timer |
| unit2_self | output | 1 | Capture/compare unit 2 uses this timer |

## Verification
- **Writes, ticks and special-event clears:** these show up on count_out after the single clock edge that samples them.
- **Reads:** read data is combinational and is compared in the middle of the strobe cycle. The wide-mode buffer capture takes effect at the edge that closes the read, so the next read of address 2 is the one that observes it.
- **External edges:** these reach the count three edges after the pin change when synchronized and one edge after it when bypassed. The bench changes the pin just after an edge and compares count_out at each following falling edge, so a synchronizer that is one stage off is caught.
- **Scoreboard:** every read expectation is queued before its strobe and taken off the queue at the falling edge where the data is valid.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned DIV_SEL_W = 2;

   typedef enum logic [1:0] {
      ADDR_CTRL   = 2'd0,
      ADDR_CNT_LO = 2'd1,
      ADDR_CNT_HI = 2'd2,
      ADDR_FLAG   = 2'd3
   } addr_e;

   typedef struct packed {
      logic                 wide;
      logic                 route_hi;
      logic [DIV_SEL_W-1:0] div_sel;
      logic                 route_lo;
      logic                 sync_off;
      logic                 src_ext;
      logic                 run;
   } ctrl_t;
endpackage

// File: rtl/tmr16_ctrl_reg.sv
module tmr16_ctrl_reg
   import tmr16_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output ctrl_t            ctrl_q,
   output logic             unit1_self,
   output logic             unit2_self
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= ctrl_t'(wdata);
      end
   end

   // Route decode: the upper bit claims both units, the lower bit claims unit 2 only.
   always_comb begin
      unit1_self = ctrl_q.route_hi;
      unit2_self = ctrl_q.route_hi | ctrl_q.route_lo;
   end
endmodule

// File: rtl/tmr16_ext_edge.sv
module tmr16_ext_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   input  logic bypass,
   input  logic active,
   output logic rise_evt
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   sel;
   logic                   prev_q;
   logic                   armed_q;

   if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= ext_in;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[SYNC_STAGES-2:0], ext_in};
      end
   end

   assign sel = bypass ? ext_in : chain_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q <= sel;
         if (!active)
            armed_q <= 1'b0;
         else if (prev_q && !sel)
            armed_q <= 1'b1;
      end
   end

   assign rise_evt = active & armed_q & sel & ~prev_q;
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_in,
   input  logic             clr,
   input  logic [SEL_W-1:0] div_sel,
   output logic             inc
);
   localparam int unsigned PC_W = (1 << SEL_W) - 1;
   typedef logic [PC_W-1:0] pc_t;

   pc_t  cnt_q;
   pc_t  limit;
   logic at_limit;

   assign limit    = pc_t'((1 << div_sel) - 1);
   assign at_limit = (cnt_q >= limit);
   assign inc      = evt_in & at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (evt_in)
         cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              rd_lo,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              clr,
   input  logic              inc,
   input  logic              flag_clr,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [BYTE_W-1:0] hi_buf_q,
   output logic              flag_q
);
   logic wrap;

   assign cnt_wr = wr_lo | (wr_hi & ~wide);
   assign wrap   = inc & ~cnt_wr & ~clr & (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_lo) begin
         if (wide) cnt_q <= {hi_buf_q, wdata};
         else      cnt_q[BYTE_W-1:0] <= wdata;
      end else if (wr_hi && !wide) begin
         cnt_q[CNT_W-1:BYTE_W] <= wdata;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_buf_q <= '0;
      else if (wide && wr_hi)
         hi_buf_q <= wdata;
      else if (wide && rd_lo)
         hi_buf_q <= cnt_q[CNT_W-1:BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (wrap)     flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end
endmodule

// File: rtl/tmr16_buffered.sv
module tmr16_buffered
   import tmr16_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   input  logic             tick_in,
   input  logic             ext_clk,
   input  logic             evt_clear,
   output logic [CNT_W-1:0] count_out,
   output logic             irq_flag,
   output logic             unit1_self,
   output logic             unit2_self
);
   localparam int unsigned BYTE_W = REG_W;

   if (CNT_W != 2 * BYTE_W) begin : g_bad_width
      $error("tmr16_buffered: CNT_W must be twice the register width");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("tmr16_buffered: SYNC_STAGES must be at least 1");
   end

   addr_e             addr;
   ctrl_t             ctrl_q;
   logic              wr_ctrl, wr_lo, wr_hi, rd_lo, flag_clr;
   logic              ext_evt, src_evt, inc, cnt_wr, psc_clr, run_q;
   logic [BYTE_W-1:0] hi_buf_q;

   assign addr     = addr_e'(bus_addr);
   assign wr_ctrl  = bus_wr && (addr == ADDR_CTRL);
   assign wr_lo    = bus_wr && (addr == ADDR_CNT_LO);
   assign wr_hi    = bus_wr && (addr == ADDR_CNT_HI);
   assign rd_lo    = bus_rd && (addr == ADDR_CNT_LO);
   assign flag_clr = bus_wr && (addr == ADDR_FLAG) && (bus_wdata == '0);
   assign run_q    = ctrl_q.run;

   tmr16_ctrl_reg ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_ctrl),
      .wdata      (bus_wdata),
      .ctrl_q     (ctrl_q),
      .unit1_self (unit1_self),
      .unit2_self (unit2_self)
   );

   tmr16_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_in   (ext_clk),
      .bypass   (ctrl_q.sync_off),
      .active   (ctrl_q.run & ctrl_q.src_ext),
      .rise_evt (ext_evt)
   );

   assign src_evt = ctrl_q.run & (ctrl_q.src_ext ? ext_evt : tick_in);
   assign psc_clr = cnt_wr | evt_clear;

   tmr16_prescaler #(.SEL_W(DIV_SEL_W)) psc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (src_evt),
      .clr     (psc_clr),
      .div_sel (ctrl_q.div_sel),
      .inc     (inc)
   );

   tmr16_count_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (ctrl_q.wide),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .rd_lo    (rd_lo),
      .wdata    (bus_wdata),
      .clr      (evt_clear),
      .inc      (inc),
      .flag_clr (flag_clr),
      .cnt_wr   (cnt_wr),
      .cnt_q    (count_out),
      .hi_buf_q (hi_buf_q),
      .flag_q   (irq_flag)
   );

   always_comb begin
      unique case (addr)
         ADDR_CTRL:   bus_rdata = ctrl_q;
         ADDR_CNT_LO: bus_rdata = count_out[BYTE_W-1:0];
         ADDR_CNT_HI: bus_rdata = ctrl_q.wide ? hi_buf_q : count_out[CNT_W-1:BYTE_W];
         default:     bus_rdata = {{(BYTE_W-1){1'b0}}, irq_flag};
      endcase
   end
endmodule

// File: rtl/tmr16_buffered_chk.sv
module tmr16_buffered_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             evt_clear,
   input logic [CNT_W-1:0] count_out,
   input logic             irq_flag,
   input logic             unit1_self,
   input logic             unit2_self,
   input logic             run_q
);
   typedef logic [CNT_W-1:0] cnt_t;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !evt_clear) |=> (count_out == $past(count_out) ||
                                   count_out == cnt_t'($past(count_out) + 1'b1))); // R3

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !bus_wr && !evt_clear) |=> $stable(count_out)); // R7

   AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> (count_out == '0 && $past(count_out) == '1)); // R11

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_flag) |-> $past(bus_wr)); // R11

   AST_EVENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clear && !bus_wr) |=> (count_out == '0)); // R12

   AST_ROUTE_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      unit1_self |-> unit2_self); // R13
endmodule

bind tmr16_buffered tmr16_buffered_chk #(.CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .evt_clear  (evt_clear),
   .count_out  (count_out),
   .irq_flag   (irq_flag),
   .unit1_self (unit1_self),
   .unit2_self (unit2_self),
   .run_q      (run_q)
);

// File: tb/tmr16_buffered_tb_top.sv
module tmr16_buffered_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic        tick_in = 1'b0, ext_clk = 1'b0, evt_clear = 1'b0;
   logic [15:0] count_out;
   logic        irq_flag, unit1_self, unit2_self;

   int tests = 0;
   int fails = 0;

   typedef struct {
      string      tag;
      logic [7:0] exp;
   } item_t;
   item_t sb_q[$];

   always #4 clk = ~clk;

   tmr16_buffered dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_in(tick_in), .ext_clk(ext_clk), .evt_clear(evt_clear),
      .count_out(count_out), .irq_flag(irq_flag),
      .unit1_self(unit1_self), .unit2_self(unit2_self)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops one expected item per read strobe, mid-cycle.
   always @(negedge clk) begin
      if (bus_rd) begin
         if (sb_q.size() == 0) begin
            check("scoreboard-empty", 32'd1, 32'd0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, {24'd0, bus_rdata}, {24'd0, it.exp});
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.tag = tag; it.exp = exp;
      sb_q.push_back(it);
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic set_cnt(input logic [15:0] v);
      wr(2'd2, v[15:8]);
      wr(2'd1, v[7:0]);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1 tick_in = 1'b1;
         @(posedge clk); #1 tick_in = 1'b0;
      end
   endtask

   task automatic ext_set(input logic v);
      @(posedge clk); #1 ext_clk = v;
      repeat (4) @(posedge clk);
   endtask

   task automatic chkp(input string tag, input logic [15:0] exp);
      @(negedge clk);
      check(tag, {16'd0, count_out}, {16'd0, exp});
   endtask

   initial begin : watchdog
      #(8 * 150000);
      check("watchdog", 32'd1, 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : driver
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chkp("R1 count", 16'h0000);
      check("R1 irq_flag", {31'd0, irq_flag}, 32'd0);
      check("R1 unit sel", {30'd0, unit1_self, unit2_self}, 32'd0);
      rd(2'd0, 8'h00, "R1 ctrl");
      rd(2'd1, 8'h00, "R1 lo");
      rd(2'd2, 8'h00, "R1 hi");
      rd(2'd3, 8'h00, "R1 flag");

      // R2 control readback
      wr(2'd0, 8'h74);
      rd(2'd0, 8'h74, "R2 ctrl");

      // R13 routing
      wr(2'd0, 8'h08); @(negedge clk);
      check("R13 route 01", {30'd0, unit1_self, unit2_self}, 32'd1);
      wr(2'd0, 8'h40); @(negedge clk);
      check("R13 route 10", {30'd0, unit1_self, unit2_self}, 32'd3);
      wr(2'd0, 8'h48); @(negedge clk);
      check("R13 route 11", {30'd0, unit1_self, unit2_self}, 32'd3);
      wr(2'd0, 8'h00); @(negedge clk);
      check("R13 route 00", {30'd0, unit1_self, unit2_self}, 32'd0);

      // R3 internal ticks, ext_clk toggling is ignored
      set_cnt(16'h0000);
      wr(2'd0, 8'h01);
      for (int i = 0; i < 5; i++) begin
         @(posedge clk); #1 tick_in = 1'b1; ext_clk = ~ext_clk;
         @(posedge clk); #1 tick_in = 1'b0; ext_clk = ~ext_clk;
      end
      chkp("R3 five ticks", 16'd5);
      rd(2'd1, 8'h05, "R3 lo read");

      // R4 divide by 2, 4, 8
      for (int d = 1; d < 4; d++) begin
         set_cnt(16'h0000);
         wr(2'd0, 8'h01 | 8'(d << 4));
         tick_n(16);
         chkp("R4 prescale", 16'(16 >> d));
      end

      // R14 count write clears prescaler progress
      set_cnt(16'h0000);
      wr(2'd0, 8'h21);
      tick_n(3);
      chkp("R14 partial", 16'h0000);
      wr(2'd1, 8'h10);
      tick_n(3);
      chkp("R14 restarted", 16'h0010);
      tick_n(1);
      chkp("R14 fourth", 16'h0011);

      // R7 stopped holds
      wr(2'd0, 8'h20);
      tick_n(8);
      chkp("R7 hold", 16'h0011);
      rd(2'd1, 8'h11, "R7 lo read");

      // R5 external edges need arming
      set_cnt(16'h0000);
      wr(2'd0, 8'h03);
      ext_set(1'b1);
      chkp("R5 unarmed rise", 16'd0);
      ext_set(1'b0);
      chkp("R5 arming fall", 16'd0);
      ext_set(1'b1);
      chkp("R5 first count", 16'd1);
      ext_set(1'b0);
      ext_set(1'b1);
      chkp("R5 second count", 16'd2);
      tick_n(3);
      chkp("R5 ticks ignored", 16'd2);
      ext_set(1'b0);

      // R6 synchronized latency: three edges
      @(posedge clk); #1 ext_clk = 1'b1;
      chkp("R6 sync before E1", 16'd2);
      chkp("R6 sync after E1", 16'd2);
      chkp("R6 sync after E2", 16'd2);
      chkp("R6 sync after E3", 16'd3);
      ext_set(1'b0);
      // R6 bypassed latency: one edge
      wr(2'd0, 8'h07);
      @(posedge clk); #1 ext_clk = 1'b1;
      chkp("R6 bypass before E1", 16'd3);
      chkp("R6 bypass after E1", 16'd4);
      ext_set(1'b0);
      wr(2'd0, 8'h00);

      // R8 byte mode
      set_cnt(16'h1234);
      rd(2'd1, 8'h34, "R8 lo");
      rd(2'd2, 8'h12, "R8 hi");
      wr(2'd2, 8'hAB);
      chkp("R8 hi write alone", 16'hAB34);
      wr(2'd1, 8'hCD);
      chkp("R8 lo write alone", 16'hABCD);

      // R9 wide-mode buffered read
      wr(2'd0, 8'h81);
      set_cnt(16'h12FF);
      chkp("R10 wide load", 16'h12FF);
      rd(2'd1, 8'hFF, "R9 lo latches");
      tick_n(1);
      chkp("R9 live moved", 16'h1300);
      rd(2'd2, 8'h12, "R9 hi from buffer");
      rd(2'd1, 8'h00, "R9 lo relatch");
      rd(2'd2, 8'h13, "R9 hi updated");

      // R10 wide-mode write staging
      wr(2'd0, 8'h80);
      wr(2'd2, 8'h56);
      chkp("R10 hi staged only", 16'h1300);
      rd(2'd2, 8'h56, "R10 hi buffer");
      wr(2'd1, 8'h78);
      chkp("R10 combined load", 16'h5678);

      // R11 overflow flag
      wr(2'd0, 8'h81);
      set_cnt(16'hFFFE);
      tick_n(1);
      chkp("R11 at max", 16'hFFFF);
      check("R11 no flag yet", {31'd0, irq_flag}, 32'd0);
      tick_n(1);
      chkp("R11 wrapped", 16'h0000);
      check("R11 flag set", {31'd0, irq_flag}, 32'd1);
      rd(2'd3, 8'h01, "R11 flag read");
      tick_n(2);
      wr(2'd3, 8'h01);
      @(negedge clk);
      check("R11 nonzero write keeps", {31'd0, irq_flag}, 32'd1);
      wr(2'd3, 8'h00);
      @(negedge clk);
      check("R11 cleared", {31'd0, irq_flag}, 32'd0);
      rd(2'd3, 8'h00, "R11 flag read clear");

      // R12 special-event clear
      tick_n(3);
      chkp("R12 before", 16'd5);
      @(posedge clk); #1 evt_clear = 1'b1;
      @(posedge clk); #1 evt_clear = 1'b0;
      chkp("R12 cleared", 16'd0);

      repeat (3) @(posedge clk);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule